// File: doc/BRIEF.md
# Security-Banked Interrupt Priority Register File

This block holds the priority bytes of an interrupt controller, one per interrupt, and one priority-mask byte per CPU. It has a single byte-wide register port. Software reaches it through two address spaces: the distributor space holds the priority bytes, and the per-CPU interface space holds the mask. Every access carries the index of the requesting CPU and a flag that marks it as non-secure.

When the security extension is switched on, a non-secure agent sees a compressed, half-range view of these values. Its priority writes land in the upper half of the range. Its reads come back shifted up by one bit. It cannot see or change the priority of group 0 interrupts. It can move the mask only while the mask already sits in the upper half. Secure agents, and all agents while the extension is off, see the raw bytes.

The low-numbered internal interrupts keep a separate priority for each CPU. Higher-numbered interrupts share one priority across all CPUs. Group membership comes in on a per-interrupt input vector and is not written through this port.

Top module: `prio_sec_regs`

## Requirements
- R1: After a synchronous reset, every priority byte and every mask byte is zero, and `rd_data` is zero.
- R2: When `sec_ext_en` is 0 or `acc_nonsec` is 0, a write stores `acc_wdata` unchanged and a read returns the stored byte unchanged.
- R3: A non-secure write (with `sec_ext_en` set) to the priority of an interrupt whose `irq_grp1` bit is 0 (group 0) leaves the stored byte unchanged.
- R4: A non-secure write to the priority of an interrupt whose `irq_grp1` bit is 1 stores `{1'b1, acc_wdata[7:1]}`.
- R5: A non-secure read of the priority of a group 0 interrupt returns zero.
- R6: A non-secure read of the priority of a group 1 interrupt returns `{stored[6:0], 1'b0}`.
- R7: A non-secure write to the mask of CPU `acc_cpu` is applied only when bit 7 of that mask is set, and then stores `{1'b1, acc_wdata[7:1]}`. Otherwise the mask keeps its value. Each CPU has its own mask.
- R8: A non-secure read of the mask returns `{mask[6:0], 1'b0}` when mask bit 7 is set, and zero otherwise.
- R9: Interrupts numbered below `NUM_INTERNAL` have a separate priority byte for each CPU, selected by `acc_cpu`. Interrupts from `NUM_INTERNAL` up to `NUM_IRQ-1` have one byte shared by all CPUs.
- R10: With `acc_cpuif`=0, the priority of interrupt n sits at address 0x400+n. With `acc_cpuif`=1, the mask sits at address 0x004. Any other address, and any interrupt number of `NUM_IRQ` or above, reads as zero and ignores writes.
- R11: `rd_data` holds the result for the access presented in the previous cycle. A read made in the same cycle as a write to the same byte returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_ext_en | input | 1 | Enables the security extension |
| irq_grp1 | input | NUM_IRQ | Group bit per interrupt: 0 means group 0, 1 means group 1 |
| acc_cpuif | input | 1 | Address space select: 0 distributor, 1 CPU interface |
| acc_addr | input | 12 | Byte offset within the selected space |
| acc_wr | input | 1 | Write enable |
| acc_wdata | input | 8 | Write data |
| acc_cpu | input | CPU_W | Index of the requesting CPU |
| acc_nonsec | input | 1 | Access is non-secure |
| rd_data | output | 8 | Registered read data |

## Verification
On every cycle, the bound checker checks the following:
- Reads of group 0 priorities and of unmapped addresses return zero on the following cycle.
- Non-secure mask reads never return an odd value.
- A non-secure mask write made while the mask is in the lower half leaves every mask unchanged.
- A raw mask write lands exactly.
- The masks are zero right after reset.

The bench's scenarios are needed to show the exact translated values, the per-CPU banking against the shared range, the aliasing of out-of-range interrupt numbers, and the old-value result of a read made in the same cycle as a write.

// File: rtl/prio_bank_pkg.sv
package prio_bank_pkg;

    localparam int PRIO_W = 8;
    localparam int ADDR_W = 12;
    localparam int IDX_W  = 10;

    localparam logic [ADDR_W-1:0] MASK_OFFSET = 12'h004;
    localparam logic [1:0]        PRIO_WINDOW = 2'b01;

    typedef logic [PRIO_W-1:0] prio_t;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_PRIO = 2'd1,
        TGT_MASK = 2'd2
    } tgt_e;

    typedef struct packed {
        tgt_e             tgt;
        logic [IDX_W-1:0] irq;
    } dec_t;

    typedef struct packed {
        logic  prio_we;
        logic  mask_we;
        prio_t prio_wdata;
        prio_t mask_wdata;
        prio_t rd_next;
    } view_t;

    function automatic prio_t ns_to_store(prio_t d);
        return {1'b1, d[PRIO_W-1:1]};
    endfunction

    function automatic prio_t store_to_ns(prio_t s);
        return {s[PRIO_W-2:0], 1'b0};
    endfunction

endpackage

// File: rtl/prio_addr_decode.sv
module prio_addr_decode
    import prio_bank_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input  logic              cpuif,
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    localparam logic [IDX_W:0] IRQ_LIMIT = (IDX_W+1)'(NUM_IRQ);

    always_comb begin
        dec.tgt = TGT_NONE;
        dec.irq = addr[IDX_W-1:0];
        if (cpuif) begin
            if (addr == MASK_OFFSET) begin
                dec.tgt = TGT_MASK;
            end
        end else if (addr[ADDR_W-1:IDX_W] == PRIO_WINDOW) begin
            if ({1'b0, addr[IDX_W-1:0]} < IRQ_LIMIT) begin
                dec.tgt = TGT_PRIO;
            end
        end
    end

endmodule

// File: rtl/prio_view.sv
module prio_view
    import prio_bank_pkg::*;
(
    input  dec_t  dec,
    input  logic  wr,
    input  prio_t wdata,
    input  logic  is_ns,
    input  logic  grp0,
    input  prio_t cur_mask,
    input  prio_t prio_rd,
    output view_t view
);
    always_comb begin
        view.prio_we    = 1'b0;
        view.mask_we    = 1'b0;
        view.prio_wdata = is_ns ? ns_to_store(wdata) : wdata;
        view.mask_wdata = is_ns ? ns_to_store(wdata) : wdata;
        view.rd_next    = '0;
        unique case (dec.tgt)
            TGT_PRIO: begin
                view.prio_we = wr && !(is_ns && grp0);
                if (!is_ns) begin
                    view.rd_next = prio_rd;
                end else if (!grp0) begin
                    view.rd_next = store_to_ns(prio_rd);
                end
            end
            TGT_MASK: begin
                view.mask_we = wr && (!is_ns || cur_mask[PRIO_W-1]);
                if (!is_ns) begin
                    view.rd_next = cur_mask;
                end else if (cur_mask[PRIO_W-1]) begin
                    view.rd_next = store_to_ns(cur_mask);
                end
            end
            default: view.rd_next = '0;
        endcase
    end

endmodule

// File: rtl/prio_store.sv
module prio_store
    import prio_bank_pkg::*;
#(
    parameter int NUM_CPU      = 2,
    parameter int NUM_IRQ      = 64,
    parameter int NUM_INTERNAL = 32,
    localparam int CPU_W       = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CPU_W-1:0] cpu,
    input  logic [IDX_W-1:0] idx,
    input  prio_t            wdata,
    output prio_t            rdata
);
    localparam int NUM_SHARED = NUM_IRQ - NUM_INTERNAL;
    localparam int BANK_IW    = (NUM_INTERNAL > 1) ? $clog2(NUM_INTERNAL) : 1;
    localparam int SH_IW      = (NUM_SHARED > 1) ? $clog2(NUM_SHARED) : 1;
    localparam logic [IDX_W-1:0] INT_LIMIT = IDX_W'(NUM_INTERNAL);

    prio_t bank_q   [NUM_CPU][NUM_INTERNAL];
    prio_t shared_q [NUM_SHARED];

    logic             is_banked;
    logic [IDX_W-1:0] sh_off;
    logic [BANK_IW-1:0] b_sel;
    logic [SH_IW-1:0]   s_sel;

    assign is_banked = idx < INT_LIMIT;
    assign sh_off    = idx - INT_LIMIT;
    assign b_sel     = idx[BANK_IW-1:0];
    assign s_sel     = sh_off[SH_IW-1:0];

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < NUM_INTERNAL; i++) begin
                    bank_q[c][i] <= '0;
                end
            end else if (we && is_banked && (cpu == CPU_W'(c))) begin
                bank_q[c][b_sel] <= wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_SHARED; i++) begin
                shared_q[i] <= '0;
            end
        end else if (we && !is_banked) begin
            shared_q[s_sel] <= wdata;
        end
    end

    assign rdata = is_banked ? bank_q[cpu][b_sel] : shared_q[s_sel];

endmodule

// File: rtl/mask_store.sv
module mask_store
    import prio_bank_pkg::*;
#(
    parameter int NUM_CPU = 2,
    localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we,
    input  logic [CPU_W-1:0]          cpu,
    input  prio_t                     wdata,
    output logic [NUM_CPU*PRIO_W-1:0] mask_vec
);
    prio_t mask_q [NUM_CPU];

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_mask
        always_ff @(posedge clk) begin
            if (rst) begin
                mask_q[c] <= '0;
            end else if (we && (cpu == CPU_W'(c))) begin
                mask_q[c] <= wdata;
            end
        end
        assign mask_vec[c*PRIO_W +: PRIO_W] = mask_q[c];
    end

endmodule

// File: rtl/prio_sec_regs.sv
module prio_sec_regs
    import prio_bank_pkg::*;
#(
    parameter int NUM_CPU      = 2,
    parameter int NUM_IRQ      = 64,
    parameter int NUM_INTERNAL = 32,
    localparam int CPU_W       = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sec_ext_en,
    input  logic [NUM_IRQ-1:0] irq_grp1,
    input  logic               acc_cpuif,
    input  logic [11:0]        acc_addr,
    input  logic               acc_wr,
    input  logic [7:0]         acc_wdata,
    input  logic [CPU_W-1:0]   acc_cpu,
    input  logic               acc_nonsec,
    output logic [7:0]         rd_data
);
    localparam int IRQ_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

    dec_t                      dec;
    view_t                     view;
    prio_t                     prio_rd;
    prio_t                     cur_mask;
    logic [NUM_CPU*PRIO_W-1:0] mask_vec;
    logic                      is_ns;
    logic                      grp0;
    prio_t                     rd_q;

    assign is_ns    = sec_ext_en && acc_nonsec;
    assign grp0     = !irq_grp1[dec.irq[IRQ_W-1:0]];
    assign cur_mask = mask_vec[PRIO_W*acc_cpu +: PRIO_W];

    prio_addr_decode #(.NUM_IRQ(NUM_IRQ)) i_dec (
        .cpuif (acc_cpuif),
        .addr  (acc_addr),
        .dec   (dec)
    );

    prio_view i_view (
        .dec      (dec),
        .wr       (acc_wr),
        .wdata    (acc_wdata),
        .is_ns    (is_ns),
        .grp0     (grp0),
        .cur_mask (cur_mask),
        .prio_rd  (prio_rd),
        .view     (view)
    );

    prio_store #(
        .NUM_CPU      (NUM_CPU),
        .NUM_IRQ      (NUM_IRQ),
        .NUM_INTERNAL (NUM_INTERNAL)
    ) i_prio (
        .clk   (clk),
        .rst   (rst),
        .we    (view.prio_we),
        .cpu   (acc_cpu),
        .idx   (dec.irq),
        .wdata (view.prio_wdata),
        .rdata (prio_rd)
    );

    mask_store #(.NUM_CPU(NUM_CPU)) i_mask (
        .clk      (clk),
        .rst      (rst),
        .we       (view.mask_we),
        .cpu      (acc_cpu),
        .wdata    (view.mask_wdata),
        .mask_vec (mask_vec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else begin
            rd_q <= view.rd_next;
        end
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/prio_sec_regs_chk.sv
module prio_sec_regs_chk #(
    parameter int NUM_CPU      = 2,
    parameter int NUM_IRQ      = 64,
    parameter int CPU_W        = 1
) (
    input logic               clk,
    input logic               rst,
    input logic               sec_ext_en,
    input logic [NUM_IRQ-1:0] irq_grp1,
    input logic               acc_cpuif,
    input logic [11:0]        acc_addr,
    input logic               acc_wr,
    input logic [7:0]         acc_wdata,
    input logic [CPU_W-1:0]   acc_cpu,
    input logic               acc_nonsec,
    input logic [7:0]         rd_data,
    input logic [NUM_CPU*8-1:0] mask_vec
);
    localparam int IRQ_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

    logic             c_ns;
    logic             c_is_mask;
    logic             c_in_range;
    logic             c_bad;
    logic             c_grp0;
    logic [7:0]       c_mask;
    logic [9:0]       c_irq;
    logic [CPU_W-1:0] cpu_d;
    logic [7:0]       wd_d;

    assign c_ns       = sec_ext_en && acc_nonsec;
    assign c_is_mask  = acc_cpuif && (acc_addr == 12'h004);
    assign c_irq      = acc_addr[9:0];
    assign c_in_range = !acc_cpuif && (acc_addr[11:10] == 2'b01) && (int'(c_irq) < NUM_IRQ);
    assign c_bad      = !c_is_mask && !c_in_range;
    assign c_grp0     = c_in_range && !irq_grp1[c_irq[IRQ_W-1:0]];
    assign c_mask     = mask_vec[8*acc_cpu +: 8];

    always_ff @(posedge clk) begin
        cpu_d <= acc_cpu;
        wd_d  <= acc_wdata;
    end

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mask_vec == '0 && rd_data == 8'h00));

    assert_grp0_raz_R5: assert property (@(posedge clk) disable iff (rst)
        (c_ns && c_grp0) |=> (rd_data == 8'h00));

    assert_unmapped_raz_R10: assert property (@(posedge clk) disable iff (rst)
        c_bad |=> (rd_data == 8'h00));

    assert_ns_mask_even_R8: assert property (@(posedge clk) disable iff (rst)
        (c_ns && c_is_mask) |=> (rd_data[0] == 1'b0));

    assert_ns_mask_drop_R7: assert property (@(posedge clk) disable iff (rst)
        (c_ns && c_is_mask && acc_wr && !c_mask[7]) |=> $stable(mask_vec));

    assert_raw_mask_write_R2: assert property (@(posedge clk) disable iff (rst)
        (!c_ns && c_is_mask && acc_wr) |=> (mask_vec[8*cpu_d +: 8] == wd_d));

endmodule

bind prio_sec_regs prio_sec_regs_chk #(
    .NUM_CPU (NUM_CPU),
    .NUM_IRQ (NUM_IRQ),
    .CPU_W   (CPU_W)
) i_chk (
    .clk        (clk),
    .rst        (rst),
    .sec_ext_en (sec_ext_en),
    .irq_grp1   (irq_grp1),
    .acc_cpuif  (acc_cpuif),
    .acc_addr   (acc_addr),
    .acc_wr     (acc_wr),
    .acc_wdata  (acc_wdata),
    .acc_cpu    (acc_cpu),
    .acc_nonsec (acc_nonsec),
    .rd_data    (rd_data),
    .mask_vec   (mask_vec)
);

// File: tb/test_prio_sec_regs.sv
module test_prio_sec_regs;

    localparam int CLK_PERIOD = 10;
    localparam int N_CPU      = 2;
    localparam int N_IRQ      = 64;

    logic             clk = 1'b0;
    logic             rst;
    logic             sec_ext_en;
    logic [N_IRQ-1:0] irq_grp1;
    logic             acc_cpuif;
    logic [11:0]      acc_addr;
    logic             acc_wr;
    logic [7:0]       acc_wdata;
    logic [0:0]       acc_cpu;
    logic             acc_nonsec;
    logic [7:0]       rd_data;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prio_sec_regs #(.NUM_CPU(N_CPU), .NUM_IRQ(N_IRQ), .NUM_INTERNAL(32)) i_prio_sec_regs (
        .clk        (clk),
        .rst        (rst),
        .sec_ext_en (sec_ext_en),
        .irq_grp1   (irq_grp1),
        .acc_cpuif  (acc_cpuif),
        .acc_addr   (acc_addr),
        .acc_wr     (acc_wr),
        .acc_wdata  (acc_wdata),
        .acc_cpu    (acc_cpu),
        .acc_nonsec (acc_nonsec),
        .rd_data    (rd_data)
    );

    typedef struct packed {
        logic        cpuif;
        logic [11:0] addr;
        logic        wr;
        logic [7:0]  wd;
        logic        cpu;
        logic        ns;
        logic        ext;
        logic        chk;
        logic [7:0]  exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 32;
    // Odd interrupts are group 1, even ones group 0 (irq_grp1 = AAAA...).
    localparam vec_t VECS [NV] = '{
        '{1'b0, 12'h428, 1'b1, 8'h5A, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'd2 },  // R2 secure write irq40
        '{1'b0, 12'h428, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 8'h5A, 8'd9 },  // R9 shared seen by cpu1
        '{1'b0, 12'h428, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 8'd5 },  // R5 NS read group 0
        '{1'b0, 12'h428, 1'b1, 8'hFF, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'd3 },  // R3 NS write group 0
        '{1'b0, 12'h428, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 8'h5A, 8'd3 },  // R3 unchanged
        '{1'b0, 12'h429, 1'b1, 8'h64, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'd4 },  // R4 NS write group 1
        '{1'b0, 12'h429, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 8'hB2, 8'd4 },  // R4 stored B2
        '{1'b0, 12'h429, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 8'h64, 8'd6 },  // R6 NS view
        '{1'b0, 12'h403, 1'b1, 8'h11, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'd9 },  // R9 banked cpu0
        '{1'b0, 12'h403, 1'b1, 8'h22, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 8'd9 },  // R9 banked cpu1
        '{1'b0, 12'h403, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 8'h11, 8'd9 },  // R9
        '{1'b0, 12'h403, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 8'h22, 8'd9 },  // R9
        '{1'b0, 12'h403, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 8'h44, 8'd6 },  // R6 banked NS view
        '{1'b0, 12'h428, 1'b1, 8'h07, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'd2 },  // R2 extension off
        '{1'b0, 12'h428, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 8'h07, 8'd2 },  // R2 raw read
        '{1'b1, 12'h004, 1'b1, 8'hF0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'd7 },  // R7 dropped, mask 0
        '{1'b1, 12'h004, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 8'd7 },  // R7
        '{1'b1, 12'h004, 1'b1, 8'h40, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'd2 },  // R2 secure mask
        '{1'b1, 12'h004, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 8'd8 },  // R8 lower half RAZ
        '{1'b1, 12'h004, 1'b1, 8'hFF, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'd7 },  // R7 dropped
        '{1'b1, 12'h004, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 8'h40, 8'd7 },  // R7 still 40
        '{1'b1, 12'h004, 1'b1, 8'h90, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 8'd2 },  // R2 cpu1 mask
        '{1'b1, 12'h004, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 8'h20, 8'd8 },  // R8 upper half
        '{1'b1, 12'h004, 1'b1, 8'h3C, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 8'd7 },  // R7 accepted
        '{1'b1, 12'h004, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 8'h9E, 8'd7 },  // R7 stored 9E
        '{1'b1, 12'h004, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 8'h40, 8'd7 },  // R7 per-CPU
        '{1'b0, 12'h464, 1'b1, 8'h77, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'd10},  // R10 irq 100
        '{1'b0, 12'h464, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 8'd10},  // R10
        '{1'b0, 12'h3FF, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 8'd10},  // R10 below window
        '{1'b1, 12'h008, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 8'd10},  // R10 other cpuif
        '{1'b0, 12'h424, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 8'd10},  // R10 no alias write
        '{1'b0, 12'h428, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'h07, 8'd2 }   // R2 secure raw
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic do_acc(input logic cpuif, input logic [11:0] addr, input logic wr,
                          input logic [7:0] wd, input logic cpu, input logic ns,
                          input logic ext, output logic [7:0] rd);
        acc_cpuif  = cpuif;
        acc_addr   = addr;
        acc_wr     = wr;
        acc_wdata  = wd;
        acc_cpu    = cpu;
        acc_nonsec = ns;
        sec_ext_en = ext;
        @(posedge clk);
        @(negedge clk);
        rd     = rd_data;
        acc_wr = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        irq_grp1   = {(N_IRQ/2){2'b10}};
        acc_cpuif  = 1'b0;
        acc_addr   = '0;
        acc_wr     = 1'b0;
        acc_wdata  = '0;
        acc_cpu    = '0;
        acc_nonsec = 1'b0;
        sec_ext_en = 1'b1;
        @(negedge clk);
        do_reset();

        // R1: reset state
        check("R1", rd_data, 8'h00);
        do_acc(1'b0, 12'h429, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, rd);
        check("R1", rd, 8'h00);
        do_acc(1'b1, 12'h004, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, rd);
        check("R1", rd, 8'h00);

        for (int i = 0; i < NV; i++) begin
            do_acc(VECS[i].cpuif, VECS[i].addr, VECS[i].wr, VECS[i].wd,
                   VECS[i].cpu, VECS[i].ns, VECS[i].ext, rd);
            if (VECS[i].chk) begin
                check($sformatf("R%0d vector %0d", VECS[i].req, i), rd, VECS[i].exp);
            end
        end

        // R11: read in the write cycle returns the old value, next read the new one
        do_acc(1'b0, 12'h432, 1'b1, 8'h33, 1'b0, 1'b0, 1'b1, rd);
        check("R11 same-cycle", rd, 8'h00);
        do_acc(1'b0, 12'h432, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, rd);
        check("R11 next", rd, 8'h33);

        // R1: reset in mid-run clears stored state
        do_reset();
        check("R1 rd_data", rd_data, 8'h00);
        do_acc(1'b0, 12'h429, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, rd);
        check("R1 prio", rd, 8'h00);
        do_acc(1'b1, 12'h004, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, rd);
        check("R1 mask", rd, 8'h00);
        do_acc(1'b0, 12'h403, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, rd);
        check("R1 banked", rd, 8'h00);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule